// File: doc/BRIEF.md
# Two-Level Page Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation structure held in ordinary memory. A requester presents one translation at a time: the virtual address, the kind of access (read, write or instruction fetch) and whether the access comes from user or supervisor level. The walker reads the upper-level (directory) entry and, for normal 4 KiB pages, the lower-level (table) entry. Each read goes through a simple 32-bit memory port. The walker answers with either a physical address or a fault code.

A directory entry can also map one aligned 4 MiB region directly, when large mappings are enabled. During the walk the block sets the accessed flag in every entry it uses. On writes it also sets the dirty flag in the final mapping entry. It writes an entry back only when one of those flags actually has to change. The root frame of the directory is held inside the block and is loaded through a strobe while the walker is idle.

Entry bit layout used throughout: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, bit 7 large mapping, bits 31:12 frame base (bits 31:22 for a large mapping).

Top module: `page_walker`

## Requirements
- R1: The directory entry is read from `{root, vaddr[31:22], 2'b00}`. The table entry is read from `{dirEntry[31:12], vaddr[21:12], 2'b00}`.
- R2: For a 4 KiB mapping, a successful response carries `{tblEntry[31:12], vaddr[11:0]}`, with respFault=0 and respKind=0.
- R3: A fetched entry with bit 0 clear ends the walk with respKind=1 (absent). The walker makes no further memory access, and every other bit of that entry has no effect.
- R4: When largeEn=1 and directory bit 7 is set, no table read occurs and the result is `{dirEntry[31:22], vaddr[21:0]}`. When largeEn=0, bit 7 is ignored and the entry is used as a table pointer.
- R5: A large-mapping entry with any of bits 21:12 nonzero ends the walk with respKind=2 (misaligned/reserved) and no write.
- R6: Every entry used in a walk has bit 5 set by a write back of the fetched value with bit 5 ORed in. No write is issued when nothing changes, and the walker never clears a bit.
- R7: A write access (reqAccess=2'b01) sets bit 6 in the final mapping entry (the table entry, or the directory entry for a large mapping). A directory entry that points to a table never gets bit 6 from the walker. A fetch (2'b10) or read (2'b00) never sets bit 6.
- R8: A user access (reqUser=1) ends with respKind=3 (privilege) and no write of the offending entry when that entry lacks bit 2. A user write also faults this way when the entry lacks bit 1. The directory is checked before the table is read. Supervisor accesses never raise kind 3.
- R9: reqReady is high only when idle. Each accepted request produces exactly one single-cycle respValid pulse.
- R10: memReq, memWe, memAddr and memWdata hold steady from the cycle memReq rises until the cycle memAck is seen.
- R11: After reset reqReady=1, respValid=0 and memReq=0. A rootLoad pulse while idle replaces the root frame used by later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rootLoad | input | 1 | Load rootFrame into the root register (taken when idle) |
| rootFrame | input | 20 | Frame number of the directory |
| largeEn | input | 1 | Enables direct 4 MiB mappings |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and accepting |
| reqVaddr | input | 32 | Virtual address |
| reqAccess | input | 2 | 00 read, 01 write, 10 fetch |
| reqUser | input | 1 | 1 = user level, 0 = supervisor |
| respValid | output | 1 | Result pulse |
| respFault | output | 1 | Result is a fault |
| respKind | output | 2 | 0 ok, 1 absent, 2 reserved, 3 privilege |
| respPaddr | output | 32 | Physical address (valid when no fault) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Byte address of the entry |
| memWdata | output | 32 | Updated entry value |
| memAck | input | 1 | Access complete; read data valid |
| memRdata | input | 32 | Entry read data |

## Verification
The embedded properties watch the cycle-level contracts on every clock: the memory request stays frozen until acknowledged, every write-back carries the accessed flag, a large walk never selects the table address, an absent directory entry leads straight to an absent response, and responses are single pulses. Only the bench scenarios can show that the right addresses are computed, that write-backs are skipped when flags are already set, that dirty lands in the correct entry, and that the privilege, alignment and enable rules pick the right outcome. The bench shows this by comparing every memory transaction and every response with an independently predicted sequence.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W     = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int FRAME_W  = VA_W - OFF_W;
  localparam int BIG_OFF  = OFF_W + IDX_W;
  localparam int BIG_W    = VA_W - BIG_OFF;
  localparam int ENT_W    = 32;

  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USER  = 2;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_BIG   = 7;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_RSVD   = 2'd2,
    FLT_PRIV   = 2'd3
  } faultKind_t;

  typedef struct packed {
    logic idle;
    logic takeReq;
    logic takeDir;
    logic takeTbl;
    logic selTbl;
  } walkStrobe_t;

  typedef struct packed {
    logic present;
    logic permOk;
    logic largeMap;
    logic rsvdBad;
    logic needWb;
  } walkFlags_t;
endpackage

// File: rtl/walk_dp.sv
module walk_dp
  import walk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  walkStrobe_t        stb,
  input  logic               rootLoad,
  input  logic [FRAME_W-1:0] rootFrame,
  input  logic               largeEn,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [1:0]         reqAccess,
  input  logic               reqUser,
  input  logic [ENT_W-1:0]   memRdata,
  output walkFlags_t         flags,
  output logic [VA_W-1:0]    memAddr,
  output logic [ENT_W-1:0]   memWdata,
  output logic [VA_W-1:0]    respPaddr
);
  logic [FRAME_W-1:0] rootReg;
  logic [VA_W-1:0]    vaddrQ;
  logic               isWrite;
  logic               isUser;
  logic               bigEnQ;
  logic               largeQ;
  logic [ENT_W-1:0]   dirQ;
  logic [ENT_W-1:0]   tblQ;
  logic               finalCur;
  logic               finalWb;
  logic [ENT_W-1:0]   wbBase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rootReg <= '0;
      vaddrQ  <= '0;
      isWrite <= 1'b0;
      isUser  <= 1'b0;
      bigEnQ  <= 1'b0;
      largeQ  <= 1'b0;
      dirQ    <= '0;
      tblQ    <= '0;
    end else begin
      if (rootLoad && stb.idle) rootReg <= rootFrame;
      if (stb.takeReq) begin
        vaddrQ  <= reqVaddr;
        isWrite <= (reqAccess == 2'b01);
        isUser  <= reqUser;
        bigEnQ  <= largeEn;
        largeQ  <= 1'b0;
      end
      if (stb.takeDir) begin
        dirQ   <= memRdata;
        largeQ <= flags.largeMap;
      end
      if (stb.takeTbl) tblQ <= memRdata;
    end
  end

  // Decision flags are taken from the entry arriving on the read port
  always_comb begin
    flags.present  = memRdata[B_PRES];
    flags.permOk   = !isUser || (memRdata[B_USER] && (!isWrite || memRdata[B_WR]));
    flags.largeMap = !stb.selTbl && bigEnQ && memRdata[B_BIG];
    flags.rsvdBad  = |memRdata[BIG_OFF-1:OFF_W];
    finalCur       = stb.selTbl || flags.largeMap;
    flags.needWb   = !memRdata[B_ACC] || (finalCur && isWrite && !memRdata[B_DIRTY]);
  end

  always_comb begin
    if (stb.selTbl)
      memAddr = {dirQ[ENT_W-1:OFF_W], vaddrQ[BIG_OFF-1:OFF_W], 2'b00};
    else
      memAddr = {rootReg, vaddrQ[VA_W-1:BIG_OFF], 2'b00};
    wbBase   = stb.selTbl ? tblQ : dirQ;
    finalWb  = stb.selTbl || largeQ;
    memWdata = wbBase;
    memWdata[B_ACC] = 1'b1;
    if (finalWb && isWrite) memWdata[B_DIRTY] = 1'b1;
    if (largeQ)
      respPaddr = {dirQ[ENT_W-1:BIG_OFF], vaddrQ[BIG_OFF-1:0]};
    else
      respPaddr = {tblQ[ENT_W-1:OFF_W], vaddrQ[OFF_W-1:0]};
  end

  AST_LARGE_NO_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.selTbl |-> !largeQ); // R4
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        memAck,
  input  walkFlags_t  flags,
  output walkStrobe_t stb,
  output logic        reqReady,
  output logic        memReq,
  output logic        memWe,
  output logic        respValid,
  output logic        respFault,
  output logic [1:0]  respKind
);
  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RD, S_DIR_WB, S_TBL_RD, S_TBL_WB, S_DONE
  } walkState_t;

  walkState_t state, nextState;
  faultKind_t kindQ, nextKind;
  logic       largeWalk, nextLarge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      kindQ     <= FLT_NONE;
      largeWalk <= 1'b0;
    end else begin
      state     <= nextState;
      kindQ     <= nextKind;
      largeWalk <= nextLarge;
    end
  end

  always_comb begin
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    nextKind  = kindQ;
    nextLarge = largeWalk;
    stb.idle  = (state == S_IDLE);
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.takeReq = 1'b1;
          nextKind    = FLT_NONE;
          nextLarge   = 1'b0;
          nextState   = S_DIR_RD;
        end
      end
      S_DIR_RD: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.takeDir = 1'b1;
          nextLarge   = flags.largeMap;
          if (!flags.present) begin
            nextKind  = FLT_ABSENT;
            nextState = S_DONE;
          end else if (!flags.permOk) begin
            nextKind  = FLT_PRIV;
            nextState = S_DONE;
          end else if (flags.largeMap && flags.rsvdBad) begin
            nextKind  = FLT_RSVD;
            nextState = S_DONE;
          end else if (flags.needWb) begin
            nextState = S_DIR_WB;
          end else begin
            nextState = flags.largeMap ? S_DONE : S_TBL_RD;
          end
        end
      end
      S_DIR_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) nextState = largeWalk ? S_DONE : S_TBL_RD;
      end
      S_TBL_RD: begin
        memReq     = 1'b1;
        stb.selTbl = 1'b1;
        if (memAck) begin
          stb.takeTbl = 1'b1;
          if (!flags.present) begin
            nextKind  = FLT_ABSENT;
            nextState = S_DONE;
          end else if (!flags.permOk) begin
            nextKind  = FLT_PRIV;
            nextState = S_DONE;
          end else begin
            nextState = flags.needWb ? S_TBL_WB : S_DONE;
          end
        end
      end
      S_TBL_WB: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        stb.selTbl = 1'b1;
        if (memAck) nextState = S_DONE;
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady  = (state == S_IDLE);
  assign respValid = (state == S_DONE);
  assign respFault = respValid && (kindQ != FLT_NONE);
  assign respKind  = respValid ? kindQ : FLT_NONE;

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |=> !respValid && reqReady); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq && $stable(memWe)); // R10
  AST_ABSENT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DIR_RD) && memAck && !flags.present |=> respValid && (respKind == FLT_ABSENT)); // R3
endmodule

// File: rtl/page_walker.sv
module page_walker
  import walk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rootLoad,
  input  logic [FRAME_W-1:0] rootFrame,
  input  logic               largeEn,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [1:0]         reqAccess,
  input  logic               reqUser,
  output logic               respValid,
  output logic               respFault,
  output logic [1:0]         respKind,
  output logic [VA_W-1:0]    respPaddr,
  output logic               memReq,
  output logic               memWe,
  output logic [VA_W-1:0]    memAddr,
  output logic [ENT_W-1:0]   memWdata,
  input  logic               memAck,
  input  logic [ENT_W-1:0]   memRdata
);
  walkStrobe_t stb;
  walkFlags_t  flags;

  walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .memAck(memAck),
    .flags(flags), .stb(stb), .reqReady(reqReady), .memReq(memReq),
    .memWe(memWe), .respValid(respValid), .respFault(respFault),
    .respKind(respKind)
  );

  walk_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rootLoad(rootLoad),
    .rootFrame(rootFrame), .largeEn(largeEn), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .reqUser(reqUser), .memRdata(memRdata),
    .flags(flags), .memAddr(memAddr), .memWdata(memWdata),
    .respPaddr(respPaddr)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWdata)); // R10
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && memWe |-> memWdata[B_ACC]); // R6
endmodule

// File: tb/test_page_walker.sv
module test_page_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rootLoad = 1'b0;
  logic [19:0] rootFrame = '0;
  logic        largeEn = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic        respValid, respFault;
  logic [1:0]  respKind;
  logic [31:0] respPaddr;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  always #4 clk = ~clk;

  page_walker i_page_walker (
    .clk(clk), .rst_n(rst_n), .rootLoad(rootLoad), .rootFrame(rootFrame),
    .largeEn(largeEn), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .reqUser(reqUser),
    .respValid(respValid), .respFault(respFault), .respKind(respKind),
    .respPaddr(respPaddr), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata)
  );

  localparam logic [31:0] EP = 32'h01, EW = 32'h02, EU = 32'h04,
                          EA = 32'h20, ED = 32'h40, EB = 32'h80;

  logic [31:0] mem [0:4095];
  int checks = 0;
  int errors = 0;
  logic [19:0] rootShadow = '0;
  logic        bigShadow = 1'b0;
  logic [31:0] qAddr[$];
  logic        qWe[$];
  logic [31:0] qData[$];
  logic [1:0]  expKind;
  logic [31:0] expPaddr;
  string       curTag = "";

  // Memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) mem[memAddr[13:2]] <= memWdata;
      else memRdata <= mem[memAddr[13:2]];
    end else begin
      memAck <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[13:2]];
  endfunction

  function automatic void push(input logic [31:0] a, input logic w, input logic [31:0] d);
    qAddr.push_back(a); qWe.push_back(w); qData.push_back(d);
  endfunction

  // Independent prediction of the transaction sequence and result
  task automatic predict(input logic [31:0] va, input logic [1:0] acc, input logic usr);
    logic [31:0] dA, d, tA, t, n;
    logic wr;
    wr = (acc == 2'b01);
    qAddr.delete(); qWe.delete(); qData.delete();
    expPaddr = '0;
    dA = {rootShadow, 12'h000} + {20'd0, va[31:22], 2'b00};
    d = rd(dA);
    push(dA, 1'b0, 32'h0);
    if (!d[0]) begin expKind = 2'd1; return; end
    if (usr && (!d[2] || (wr && !d[1]))) begin expKind = 2'd3; return; end
    if (bigShadow && d[7]) begin
      if (d[21:12] != 0) begin expKind = 2'd2; return; end
      n = d | EA | (wr ? ED : 32'h0);
      if (n != d) push(dA, 1'b1, n);
      expKind = 2'd0;
      expPaddr = {d[31:22], va[21:0]};
      return;
    end
    if (!d[5]) push(dA, 1'b1, d | EA);
    tA = {d[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    t = rd(tA);
    push(tA, 1'b0, 32'h0);
    if (!t[0]) begin expKind = 2'd1; return; end
    if (usr && (!t[2] || (wr && !t[1]))) begin expKind = 2'd3; return; end
    n = t | EA | (wr ? ED : 32'h0);
    if (n != t) push(tA, 1'b1, n);
    expKind = 2'd0;
    expPaddr = {t[31:12], va[11:0]};
  endtask

  // Per-clock comparison of memory transactions against the prediction
  always @(negedge clk) begin
    if (rst_n && memReq && !memAck) begin
      if (qAddr.size() == 0) begin
        check(1'b0, curTag, "unexpected memory access", memAddr, 32'h0);
      end else begin
        logic [31:0] a, dd;
        logic w;
        a = qAddr.pop_front(); w = qWe.pop_front(); dd = qData.pop_front();
        check(memAddr == a, curTag, "memAddr", memAddr, a);
        check(memWe == w, curTag, "memWe", {31'd0, memWe}, {31'd0, w});
        if (w) check(memWdata == dd, curTag, "memWdata", memWdata, dd);
      end
    end
  end

  task automatic run(input logic [31:0] va, input logic [1:0] acc,
                     input logic usr, input string tag);
    int waitCnt;
    curTag = tag;
    predict(va, acc, usr);
    @(negedge clk);
    check(reqReady == 1'b1, tag, "reqReady idle", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqVaddr = va; reqAccess = acc; reqUser = usr;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R9", "reqReady busy", {31'd0, reqReady}, 32'd0);
    waitCnt = 0;
    while (!respValid && waitCnt < 60) begin
      @(negedge clk);
      waitCnt++;
    end
    check(respValid == 1'b1, tag, "respValid", {31'd0, respValid}, 32'd1);
    check(respKind == expKind, tag, "respKind", {30'd0, respKind}, {30'd0, expKind});
    check(respFault == (expKind != 2'd0), tag, "respFault", {31'd0, respFault},
          {31'd0, expKind != 2'd0});
    if (expKind == 2'd0) check(respPaddr == expPaddr, tag, "respPaddr", respPaddr, expPaddr);
    check(qAddr.size() == 0, tag, "missing memory accesses", qAddr.size(), 32'd0);
    @(negedge clk);
    check(respValid == 1'b0, "R9", "single response pulse", {31'd0, respValid}, 32'd0);
  endtask

  task automatic loadRoot(input logic [19:0] f);
    @(negedge clk);
    rootLoad = 1'b1; rootFrame = f;
    @(negedge clk);
    rootLoad = 1'b0;
    rootShadow = f;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[12'h400] = 32'h00002000 | EP | EW | EU;
    mem[12'h800] = 32'h12345000 | EP | EW | EU;
    mem[12'h401] = 32'hFFFFFFFE;
    mem[12'h805] = 32'h12345000 | EW | EU | EA;
    mem[12'h402] = 32'h0C000000 | EB | EP | EW | EU;
    mem[12'h403] = 32'h0C401000 | EB | EP | EW | EU;
    mem[12'h404] = 32'h00003000 | EP | EW;
    mem[12'hC06] = 32'h0ABCD000 | EP | EW;
    mem[12'h807] = 32'h00777000 | EP | EU | EA;
    mem[12'h809] = 32'h00999000 | EP | EW | EU;
    mem[12'h0AB] = 32'h00555000 | EP | EW | EU;
    mem[12'h000] = 32'h00002000 | EP | EW | EU | EA;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(reqReady == 1'b1, "R11", "reqReady after reset", {31'd0, reqReady}, 32'd1);
    check(respValid == 1'b0, "R11", "respValid after reset", {31'd0, respValid}, 32'd0);
    check(memReq == 1'b0, "R11", "memReq after reset", {31'd0, memReq}, 32'd0);

    loadRoot(20'h00001);                        // R11 root load
    run(32'h00000ABC, 2'b00, 1'b1, "R1");       // R1/R2/R6 both entries get accessed
    run(32'h00000DEF, 2'b00, 1'b0, "R6");       // R6 flags already set: no writes
    run(32'h00000123, 2'b01, 1'b1, "R7");       // R7 dirty in table entry only
    run(32'h00400000, 2'b00, 1'b0, "R3");       // R3 absent directory, other bits ignored
    run(32'h00005010, 2'b00, 1'b0, "R3");       // R3 absent table entry
    run(32'h00009044, 2'b10, 1'b1, "R7");       // R7 fetch never marks dirty
    largeEn = 1'b1; bigShadow = 1'b1;
    run(32'h008ABCDE, 2'b01, 1'b0, "R4");       // R4/R7 large write
    run(32'h00812345, 2'b00, 1'b1, "R4");       // R4 large read, no write-back
    run(32'h00C00010, 2'b00, 1'b0, "R5");       // R5 misaligned large entry
    largeEn = 1'b0; bigShadow = 1'b0;
    run(32'h008ABCDE, 2'b00, 1'b0, "R4");       // R4 bit 7 ignored when disabled
    run(32'h010060F0, 2'b00, 1'b1, "R8");       // R8 user vs supervisor directory
    run(32'h010060F0, 2'b00, 1'b0, "R8");       // R8 supervisor allowed
    run(32'h00007010, 2'b01, 1'b1, "R8");       // R8 user write to read-only
    run(32'h00007010, 2'b00, 1'b1, "R8");       // R8 user read allowed
    run(32'h00007010, 2'b01, 1'b0, "R8");       // R8 supervisor write allowed
    loadRoot(20'h00000);                        // R11 new root frame
    run(32'h00000123, 2'b00, 1'b0, "R11");
    run(32'h00000456, 2'b00, 1'b0, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule